// File: doc/BRIEF.md
# Variable-Length Instruction Byte Predecoder

This block walks a stream of fixed-width fetch words one byte per clock and cuts out one variable-length instruction at a time. Each instruction is split into its legacy prefix bytes, up to two escape bytes that select an opcode map, the opcode itself, an optional addressing-form byte (ModRM), an optional scale-index-base byte (SIB), a displacement and an immediate. Fields that run past the end of one fetch word are finished from the next one.

A fetch unit offers words over a valid/ready handshake, together with the word's byte address and the address where decoding is to start. When the last byte of an instruction has been taken, the block pulses a done flag for one cycle and presents all fields, the byte length and the address of the following instruction. These outputs hold until the next done pulse. While it has no unconsumed bytes the block raises a need-more-bytes flag and does nothing else.

Which opcodes carry a ModRM byte, and the size class of their immediate, come from small fixed tables inside the block.

Top module: `insn_predecode`

## Requirements
- R1: While reset is held and in the first cycle after it, `needMore` and `fetchReady` are 1 and `instDone` is 0.
- R2: An accepted word whose address is below `startPc` is consumed from byte offset `startPc - fetchAddr`; any other word is consumed from offset 0. Byte k of a word sits in `fetchData[8k+7:8k]`.
- R3: Bytes 26, 2E, 36, 3E, 64, 65, 66, 67, F0, F2 and F3 (hex) are prefixes and are skipped. Byte 66 sets `opSizeOvr` and byte 67 sets `addrSizeOvr`. The first byte that is not a prefix is treated as the opcode, or as an escape.
- R4: `opMap` is 0 for a plain opcode. It is 1 after escape 0F, 2 after 0F 38, and 3 after 0F 3A. `opcode` is the byte that follows the escapes.
- R5: A ModRM byte follows these opcodes. In map 0: 00-3F with bit 2 clear, 69, 6B, 80-8F, C6 and C7. In map 1: 10-2F, 40-4F, AF, B6, B7, BE and BF. In maps 2 and 3: every opcode. A SIB byte follows when ModRM mod (bits 7:6) is not 3 and rm (bits 2:0) is 4.
- R6: The displacement is 1 byte when mod is 1 and 4 bytes when mod is 2. It is also 4 bytes when mod is 0 and either rm is 5 or the SIB base (bits 2:0) is 5. Otherwise it is absent. It is assembled little-endian into `disp`.
- R7: Immediate sizes: 1 byte for map-0 opcodes 00-3F with low three bits 4, and for 6A, 6B, 70-7F, 80, 82, 83, B0-B7, C6, CD and EB, and for all of map 3. Map-0 opcodes 00-3F with low three bits 5, and 68, 69, 81, B8-BF, C7, E8 and E9, and map-1 opcodes 80-8F take 4 bytes, or 2 bytes with the 66 prefix. Map-0 opcodes A0-A3 take 8 bytes, or 4 bytes with the 67 prefix. The immediate is assembled little-endian into `imm`.
- R8: A displacement or immediate that crosses a fetch-word boundary is stitched together from the bytes of both words, with no gap or repeat.
- R9: `instLen` equals the number of bytes from the instruction's first byte through its last byte, and `nextPc` equals the first byte's address plus `instLen`.
- R10: `instDone` is high for exactly one cycle per instruction. The fields it presents belong to that instruction alone, with nothing carried over from the previous one. Fields the instruction lacks read 0.
- R11: Once every byte of the held word is consumed, `needMore` rises, no instruction completes, and decoding resumes where it stopped when the next word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch word offered |
| fetchReady | output | 1 | Block can take a word |
| fetchAddr | input | AW (32) | Byte address of the offered word |
| fetchData | input | 8*WORD_BYTES (64) | Offered word, byte 0 in the low bits |
| startPc | input | AW (32) | Address at which decoding begins |
| needMore | output | 1 | No unconsumed byte is held |
| instDone | output | 1 | One-cycle pulse: an instruction completed |
| instLen | output | LEN_W (5) | Byte length of the completed instruction |
| nextPc | output | AW (32) | Address after the completed instruction |
| opSizeOvr | output | 1 | Operand-size prefix seen |
| addrSizeOvr | output | 1 | Address-size prefix seen |
| opMap | output | 2 | Opcode map selected by escapes |
| opcode | output | 8 | Opcode byte |
| hasModrm | output | 1 | ModRM byte present |
| modrm | output | 8 | ModRM byte |
| hasSib | output | 1 | SIB byte present |
| sib | output | 8 | SIB byte |
| disp | output | 32 | Displacement |
| imm | output | 64 | Immediate |

## Verification
The assertions assume that the fetch side offers words in ascending address order, starting at or just below the first instruction. They also assume no word is offered while `fetchReady` is low, so the bytes seen form one contiguous stream. The stimulus keeps to this. It presents a word only after sampling `fetchReady` high, and drops `fetchValid` one cycle later. In the second run it starts inside a word by setting `startPc` three bytes past the word address. Every stream is built only from opcodes listed in the tables, so the control never leaves its legal states.

// File: rtl/insn_predecode_pkg.sv
package insn_predecode_pkg;

  localparam int DISP_W = 32;
  localparam int IMM_W  = 64;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_RESET, ST_PREFIX, ST_OP2, ST_OP38, ST_OP3A,
    ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_ERR
  } state_t;

  typedef enum logic [1:0] {IMM_NONE, IMM_BYTE, IMM_OPSZ, IMM_ADDR} immClass_t;

  // Strobes from control to datapath for the byte at the current offset.
  typedef struct packed {
    logic       consume;
    logic       setOpSz;
    logic       setAddrSz;
    logic       latchOp;
    logic [1:0] opMap;
    logic       latchModrm;
    logic       latchSib;
    logic       collectDisp;
    logic       collectImm;
    logic       clrCount;
    logic       finish;
  } strobe_t;

  function automatic logic isPrefix(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic needsModrm(input logic [1:0] map, input logic [7:0] b);
    case (map)
      2'd0: return (b[7:6] == 2'b00 && !b[2]) || b == 8'h69 || b == 8'h6B ||
                   b[7:4] == 4'h8 || b == 8'hC6 || b == 8'hC7;
      2'd1: return b[7:4] == 4'h1 || b[7:4] == 4'h2 || b[7:4] == 4'h4 ||
                   b == 8'hAF || b == 8'hB6 || b == 8'hB7 || b == 8'hBE || b == 8'hBF;
      default: return 1'b1;
    endcase
  endfunction

  function automatic immClass_t immClass(input logic [1:0] map, input logic [7:0] b);
    if (map == 2'd3) return IMM_BYTE;
    if (map == 2'd1) return (b[7:4] == 4'h8) ? IMM_OPSZ : IMM_NONE;
    if (map == 2'd2) return IMM_NONE;
    if (b[7:6] == 2'b00 && b[2:0] == 3'd4) return IMM_BYTE;
    if (b[7:6] == 2'b00 && b[2:0] == 3'd5) return IMM_OPSZ;
    if (b[7:4] == 4'h7 || b[7:3] == 5'b10110) return IMM_BYTE;
    if (b[7:3] == 5'b10111) return IMM_OPSZ;
    if (b[7:2] == 6'b101000) return IMM_ADDR;
    case (b)
      8'h6A, 8'h6B, 8'h80, 8'h82, 8'h83, 8'hC6, 8'hCD, 8'hEB: return IMM_BYTE;
      8'h68, 8'h69, 8'h81, 8'hC7, 8'hE8, 8'hE9:               return IMM_OPSZ;
      default:                                                return IMM_NONE;
    endcase
  endfunction

endpackage

// File: rtl/insn_predecode_ctrl.sv
module insn_predecode_ctrl
  import insn_predecode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteAvail,
  input  logic [7:0]       curByte,
  input  logic [CNT_W-1:0] collectCnt,
  input  logic             opSzSeen,
  input  logic             addrSzSeen,
  output strobe_t          stb,
  output state_t           state
);

  state_t     nState;
  logic [2:0] dispSize, nDispSize;
  logic [3:0] immSize, nImmSize;
  logic [1:0] modReg, nModReg;
  logic       doOp;
  logic [1:0] mapSel;
  logic [2:0] tailDisp;
  logic       doTail;
  logic [3:0] opImm;

  always_comb begin
    case (immClass(mapSel, curByte))
      IMM_BYTE: opImm = 4'd1;
      IMM_OPSZ: opImm = opSzSeen ? 4'd2 : 4'd4;
      IMM_ADDR: opImm = addrSzSeen ? 4'd4 : 4'd8;
      default:  opImm = 4'd0;
    endcase
  end

  always_comb begin
    stb       = '0;
    nState    = state;
    nDispSize = dispSize;
    nImmSize  = immSize;
    nModReg   = modReg;
    doOp      = 1'b0;
    mapSel    = 2'd0;
    doTail    = 1'b0;
    tailDisp  = 3'd0;
    if (state == ST_RESET) begin
      nState = ST_PREFIX;
    end else if (byteAvail) begin
      stb.consume = 1'b1;
      case (state)
        ST_PREFIX: begin
          if (isPrefix(curByte)) begin
            stb.setOpSz   = (curByte == 8'h66);
            stb.setAddrSz = (curByte == 8'h67);
          end else if (curByte == 8'h0F) begin
            nState = ST_OP2;
          end else begin
            doOp = 1'b1;
          end
        end
        ST_OP2: begin
          if (curByte == 8'h38)      nState = ST_OP38;
          else if (curByte == 8'h3A) nState = ST_OP3A;
          else begin
            doOp = 1'b1;
            mapSel = 2'd1;
          end
        end
        ST_OP38: begin doOp = 1'b1; mapSel = 2'd2; end
        ST_OP3A: begin doOp = 1'b1; mapSel = 2'd3; end
        ST_MODRM: begin
          stb.latchModrm = 1'b1;
          nModReg = curByte[7:6];
          if (curByte[7:6] != 2'b11 && curByte[2:0] == 3'd4) begin
            nState = ST_SIB;
          end else begin
            doTail = 1'b1;
            if (curByte[7:6] == 2'b01)      tailDisp = 3'd1;
            else if (curByte[7:6] == 2'b10) tailDisp = 3'd4;
            else if (curByte[7:6] == 2'b00 && curByte[2:0] == 3'd5) tailDisp = 3'd4;
          end
        end
        ST_SIB: begin
          stb.latchSib = 1'b1;
          doTail = 1'b1;
          if (modReg == 2'b01)      tailDisp = 3'd1;
          else if (modReg == 2'b10) tailDisp = 3'd4;
          else if (curByte[2:0] == 3'd5) tailDisp = 3'd4;
        end
        ST_DISP: begin
          stb.collectDisp = 1'b1;
          if (collectCnt + 4'd1 == {1'b0, dispSize}) begin
            stb.clrCount = 1'b1;
            if (immSize != 4'd0) nState = ST_IMM;
            else begin
              stb.finish = 1'b1;
              nState = ST_PREFIX;
            end
          end
        end
        ST_IMM: begin
          stb.collectImm = 1'b1;
          if (collectCnt + 4'd1 == immSize) begin
            stb.clrCount = 1'b1;
            stb.finish   = 1'b1;
            nState       = ST_PREFIX;
          end
        end
        default: begin
          stb.consume = 1'b0;
          nState = ST_ERR;
        end
      endcase

      if (doOp) begin
        stb.latchOp = 1'b1;
        stb.opMap   = mapSel;
        nImmSize    = opImm;
        if (needsModrm(mapSel, curByte)) nState = ST_MODRM;
        else if (opImm != 4'd0)          nState = ST_IMM;
        else begin
          stb.finish = 1'b1;
          nState = ST_PREFIX;
        end
      end

      if (doTail) begin
        nDispSize = tailDisp;
        if (tailDisp != 3'd0)      nState = ST_DISP;
        else if (immSize != 4'd0)  nState = ST_IMM;
        else begin
          stb.finish = 1'b1;
          nState = ST_PREFIX;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RESET;
      dispSize <= '0;
      immSize  <= '0;
      modReg   <= '0;
    end else begin
      state    <= nState;
      dispSize <= nDispSize;
      immSize  <= nImmSize;
      modReg   <= nModReg;
    end
  end

endmodule

// File: rtl/insn_predecode_dpath.sv
module insn_predecode_dpath
  import insn_predecode_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int AW         = 32,
  parameter int LEN_W      = 5,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int OFF_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [AW-1:0]     fetchAddr,
  input  logic [WORD_W-1:0] fetchData,
  input  logic [AW-1:0]     startPc,
  input  strobe_t           stb,
  output logic              fetchReady,
  output logic              byteAvail,
  output logic [7:0]        curByte,
  output logic [CNT_W-1:0]  collectCnt,
  output logic              opSzSeen,
  output logic              addrSzSeen,
  output logic              instDone,
  output logic [LEN_W-1:0]  instLen,
  output logic [AW-1:0]     nextPc,
  output logic              opSizeOvr,
  output logic              addrSizeOvr,
  output logic [1:0]        opMap,
  output logic [7:0]        opcode,
  output logic              hasModrm,
  output logic [7:0]        modrm,
  output logic              hasSib,
  output logic [7:0]        sib,
  output logic [DISP_W-1:0] disp,
  output logic [IMM_W-1:0]  imm
);

  logic [WORD_W-1:0] wordBuf;
  logic              wordValid;
  logic [AW-1:0]     baseAddr, origPc, orgNow, lenFull;
  logic [OFF_W-1:0]  offset;
  logic [OFF_W:0]    nextOff;
  logic              instActive;

  // Working field registers and their next values.
  logic              wOpSz, wAddrSz, nOpSz, nAddrSz;
  logic [1:0]        wMap, nMap;
  logic [7:0]        wOp, nOp, wModrm, nModrm, wSib, nSib;
  logic              wHasM, nHasM, wHasS, nHasS;
  logic [DISP_W-1:0] wDisp, nDisp;
  logic [IMM_W-1:0]  wImm, nImm;

  assign fetchReady = !wordValid;
  assign byteAvail  = wordValid;
  assign curByte    = wordBuf[{offset, 3'b000} +: 8];
  assign nextOff    = {1'b0, offset} + 1'b1;
  assign opSzSeen   = wOpSz;
  assign addrSzSeen = wAddrSz;
  assign orgNow     = instActive ? origPc : baseAddr + AW'(offset);
  assign lenFull    = baseAddr + AW'(nextOff) - orgNow;

  always_comb begin
    nOpSz   = wOpSz | stb.setOpSz;
    nAddrSz = wAddrSz | stb.setAddrSz;
    nMap    = stb.latchOp ? stb.opMap : wMap;
    nOp     = stb.latchOp ? curByte : wOp;
    nHasM   = wHasM | stb.latchModrm;
    nModrm  = stb.latchModrm ? curByte : wModrm;
    nHasS   = wHasS | stb.latchSib;
    nSib    = stb.latchSib ? curByte : wSib;
    nDisp   = stb.collectDisp ? wDisp | (DISP_W'(curByte) << {collectCnt[1:0], 3'b000}) : wDisp;
    nImm    = stb.collectImm ? wImm | (IMM_W'(curByte) << {collectCnt[2:0], 3'b000}) : wImm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordBuf    <= '0;
      wordValid  <= 1'b0;
      baseAddr   <= '0;
      offset     <= '0;
      instActive <= 1'b0;
      origPc     <= '0;
      collectCnt <= '0;
      {wOpSz, wAddrSz, wMap, wOp, wHasM, wModrm, wHasS, wSib, wDisp, wImm} <= '0;
      instDone   <= 1'b0;
      instLen    <= '0;
      nextPc     <= '0;
      {opSizeOvr, addrSizeOvr, opMap, opcode, hasModrm, modrm, hasSib, sib, disp, imm} <= '0;
    end else begin
      instDone <= stb.finish;
      if (fetchValid && fetchReady) begin
        wordBuf   <= fetchData;
        wordValid <= 1'b1;
        baseAddr  <= fetchAddr;
        offset    <= (fetchAddr < startPc) ? OFF_W'(startPc - fetchAddr) : '0;
      end else if (stb.consume) begin
        if (nextOff == (OFF_W + 1)'(WORD_BYTES)) begin
          wordValid <= 1'b0;
          offset    <= '0;
          baseAddr  <= baseAddr + AW'(WORD_BYTES);
        end else begin
          offset <= nextOff[OFF_W-1:0];
        end
      end

      if (stb.clrCount) collectCnt <= '0;
      else if (stb.collectDisp || stb.collectImm) collectCnt <= collectCnt + 1'b1;

      if (stb.finish) begin
        instActive <= 1'b0;
        instLen    <= LEN_W'(lenFull);
        nextPc     <= orgNow + lenFull;
        {opSizeOvr, addrSizeOvr, opMap, opcode, hasModrm, modrm, hasSib, sib, disp, imm}
          <= {nOpSz, nAddrSz, nMap, nOp, nHasM, nModrm, nHasS, nSib, nDisp, nImm};
        {wOpSz, wAddrSz, wMap, wOp, wHasM, wModrm, wHasS, wSib, wDisp, wImm} <= '0;
      end else begin
        if (stb.consume && !instActive) begin
          instActive <= 1'b1;
          origPc     <= orgNow;
        end
        {wOpSz, wAddrSz, wMap, wOp, wHasM, wModrm, wHasS, wSib, wDisp, wImm}
          <= {nOpSz, nAddrSz, nMap, nOp, nHasM, nModrm, nHasS, nSib, nDisp, nImm};
      end
    end
  end

endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import insn_predecode_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int AW         = 32,
  parameter int LEN_W      = 5,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  output logic              fetchReady,
  input  logic [AW-1:0]     fetchAddr,
  input  logic [WORD_W-1:0] fetchData,
  input  logic [AW-1:0]     startPc,
  output logic              needMore,
  output logic              instDone,
  output logic [LEN_W-1:0]  instLen,
  output logic [AW-1:0]     nextPc,
  output logic              opSizeOvr,
  output logic              addrSizeOvr,
  output logic [1:0]        opMap,
  output logic [7:0]        opcode,
  output logic              hasModrm,
  output logic [7:0]        modrm,
  output logic              hasSib,
  output logic [7:0]        sib,
  output logic [31:0]       disp,
  output logic [63:0]       imm
);

  strobe_t          stb;
  state_t           fsmState;
  logic             byteAvail, opSzSeen, addrSzSeen, fsmInError;
  logic [7:0]       curByte;
  logic [CNT_W-1:0] collectCnt;

  assign needMore   = !byteAvail;
  assign fsmInError = (fsmState == ST_ERR);

  insn_predecode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteAvail(byteAvail), .curByte(curByte),
    .collectCnt(collectCnt), .opSzSeen(opSzSeen), .addrSzSeen(addrSzSeen),
    .stb(stb), .state(fsmState)
  );

  insn_predecode_dpath #(.WORD_BYTES(WORD_BYTES), .AW(AW), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchData(fetchData), .startPc(startPc), .stb(stb), .fetchReady(fetchReady),
    .byteAvail(byteAvail), .curByte(curByte), .collectCnt(collectCnt),
    .opSzSeen(opSzSeen), .addrSzSeen(addrSzSeen), .instDone(instDone),
    .instLen(instLen), .nextPc(nextPc), .opSizeOvr(opSizeOvr),
    .addrSizeOvr(addrSizeOvr), .opMap(opMap), .opcode(opcode),
    .hasModrm(hasModrm), .modrm(modrm), .hasSib(hasSib), .sib(sib),
    .disp(disp), .imm(imm)
  );

endmodule

// File: rtl/insn_predecode_chk.sv
module insn_predecode_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic             fetchReady,
  input logic             needMore,
  input logic             instDone,
  input logic [LEN_W-1:0] instLen,
  input logic             hasModrm,
  input logic [7:0]       modrm,
  input logic             hasSib,
  input logic [31:0]      disp,
  input logic             fsmInError
);

  AST_NO_ERROR_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !fsmInError); // R10

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && fetchReady |=> !needMore); // R2

  AST_STALL_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    needMore |=> !instDone); // R11

  AST_SIB_NEEDS_MODRM: assert property (@(posedge clk) disable iff (!rstN)
    instDone && hasSib |-> hasModrm && modrm[7:6] != 2'b11 && modrm[2:0] == 3'd4); // R5

  AST_NO_MODRM_NO_DISP: assert property (@(posedge clk) disable iff (!rstN)
    instDone && !hasModrm |-> disp == 32'd0); // R6

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    instDone |-> instLen != '0); // R9

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !instDone |-> $stable(instLen)); // R10

endmodule

bind insn_predecode insn_predecode_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .needMore(needMore), .instDone(instDone), .instLen(instLen),
  .hasModrm(hasModrm), .modrm(modrm), .hasSib(hasSib), .disp(disp),
  .fsmInError(fsmInError)
);

// File: tb/sim_insn_predecode.sv
module sim_insn_predecode;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic        fetchReady;
  logic [31:0] fetchAddr = '0;
  logic [63:0] fetchData = '0;
  logic [31:0] startPc = '0;
  logic        needMore, instDone;
  logic [4:0]  instLen;
  logic [31:0] nextPc;
  logic        opSizeOvr, addrSizeOvr, hasModrm, hasSib;
  logic [1:0]  opMap;
  logic [7:0]  opcode, modrm, sib;
  logic [31:0] disp;
  logic [63:0] imm;

  int vectors = 0;
  int fails   = 0;
  int dones   = 0;

  always #10 clk = ~clk;

  insn_predecode u0 (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
    .fetchAddr(fetchAddr), .fetchData(fetchData), .startPc(startPc),
    .needMore(needMore), .instDone(instDone), .instLen(instLen), .nextPc(nextPc),
    .opSizeOvr(opSizeOvr), .addrSizeOvr(addrSizeOvr), .opMap(opMap),
    .opcode(opcode), .hasModrm(hasModrm), .modrm(modrm), .hasSib(hasSib),
    .sib(sib), .disp(disp), .imm(imm)
  );

  typedef struct {
    string       tag;
    logic        opSz, adSz;
    logic [1:0]  map;
    logic [7:0]  op;
    logic        hasM;
    logic [7:0]  m;
    logic        hasS;
    logic [7:0]  s;
    logic [31:0] d;
    logic [63:0] i;
    logic [4:0]  len;
    logic [31:0] npc;
  } exp_t;

  exp_t expQ[$];
  logic [31:0] runPc;

  logic [7:0] stream [0:63] = '{
    8'h66, 8'h05, 8'h34, 8'h12,
    8'h8B, 8'h44, 8'h24, 8'h08,
    8'h81, 8'h80, 8'h78, 8'h56, 8'h34, 8'h12, 8'hEF, 8'hBE, 8'hAD, 8'hDE,
    8'hA1, 8'h88, 8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11,
    8'h0F, 8'h3A, 8'h0F, 8'hC1, 8'h05,
    8'h0F, 8'h84, 8'h10, 8'h20, 8'h30, 8'h40,
    8'h8B, 8'h04, 8'h25, 8'h00, 8'h10, 8'h00, 8'h00,
    8'h90,
    8'h67, 8'hA1, 8'h44, 8'h33, 8'h22, 8'h11,
    8'h0F, 8'h38, 8'h00, 8'hC1,
    8'h8B, 8'h05, 8'h78, 8'h56, 8'h34, 8'h12,
    8'h90, 8'h90
  };

  task automatic check(input string what, input string tag, input logic [63:0] got,
                       input logic [63:0] expv);
    vectors++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, expv);
    end
  endtask

  // Driver side: push one expected instruction, advancing the running PC.
  task automatic pushInst(input string tag, input logic opSz, input logic adSz,
      input logic [1:0] map, input logic [7:0] op, input logic hasM, input logic [7:0] m,
      input logic hasS, input logic [7:0] s, input logic [31:0] d, input logic [63:0] i,
      input logic [4:0] len);
    exp_t e;
    e.tag = tag; e.opSz = opSz; e.adSz = adSz; e.map = map; e.op = op;
    e.hasM = hasM; e.m = m; e.hasS = hasS; e.s = s; e.d = d; e.i = i; e.len = len;
    runPc = runPc + 32'(len);
    e.npc = runPc;
    expQ.push_back(e);
  endtask

  task automatic sendWord(input logic [31:0] addr, input logic [63:0] data);
    @(negedge clk);
    while (!fetchReady) @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = addr;
    fetchData  = data;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  // Monitor: pop and compare on every completion pulse.
  always @(negedge clk) begin
    if (rstN && instDone) begin
      dones++;
      if (expQ.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R10 extra completion: got opcode %h expected none", opcode);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check("opSizeOvr", e.tag, 64'(opSizeOvr), 64'(e.opSz));
        check("addrSizeOvr", e.tag, 64'(addrSizeOvr), 64'(e.adSz));
        check("opMap", e.tag, 64'(opMap), 64'(e.map));
        check("opcode", e.tag, 64'(opcode), 64'(e.op));
        check("hasModrm", e.tag, 64'(hasModrm), 64'(e.hasM));
        check("modrm", e.tag, 64'(modrm), 64'(e.hasM ? e.m : 8'h00));
        check("hasSib", e.tag, 64'(hasSib), 64'(e.hasS));
        check("sib", e.tag, 64'(sib), 64'(e.hasS ? e.s : 8'h00));
        check("disp", e.tag, 64'(disp), 64'(e.d));
        check("imm", e.tag, imm, e.i);
        check("instLen", "R9", 64'(instLen), 64'(e.len));
        check("nextPc", "R9", 64'(nextPc), 64'(e.npc));
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL R11 watchdog: got hung run, expected completion");
    finishRun();
  end

  initial begin
    int doneMark;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("needMore in reset", "R1", 64'(needMore), 64'd1);
    check("fetchReady in reset", "R1", 64'(fetchReady), 64'd1);
    check("instDone in reset", "R1", 64'(instDone), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("needMore after reset", "R1", 64'(needMore), 64'd1);
    check("instDone after reset", "R1", 64'(instDone), 64'd0);

    // Main stream at 0x1000
    runPc = 32'h1000;
    startPc = 32'h1000;
    pushInst("R3 R7 R10", 1, 0, 0, 8'h05, 0, 0, 0, 0, 0, 64'h1234, 4);
    pushInst("R5 R6 R10", 0, 0, 0, 8'h8B, 1, 8'h44, 1, 8'h24, 32'h08, 0, 4);
    pushInst("R6 R7 R8", 0, 0, 0, 8'h81, 1, 8'h80, 0, 0, 32'h12345678, 64'hDEADBEEF, 10);
    pushInst("R7 R8", 0, 0, 0, 8'hA1, 0, 0, 0, 0, 0, 64'h1122334455667788, 9);
    pushInst("R4 R7", 0, 0, 3, 8'h0F, 1, 8'hC1, 0, 0, 0, 64'h05, 5);
    pushInst("R4 R7 R8", 0, 0, 1, 8'h84, 0, 0, 0, 0, 0, 64'h40302010, 6);
    pushInst("R5 R6", 0, 0, 0, 8'h8B, 1, 8'h04, 1, 8'h25, 32'h00001000, 0, 7);
    pushInst("R10", 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 1);
    pushInst("R3 R7 R8", 0, 1, 0, 8'hA1, 0, 0, 0, 0, 0, 64'h11223344, 6);
    pushInst("R4 R5", 0, 0, 2, 8'h00, 1, 8'hC1, 0, 0, 0, 0, 4);
    pushInst("R6 R8", 0, 0, 0, 8'h8B, 1, 8'h05, 0, 0, 32'h12345678, 0, 6);
    pushInst("R10", 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 1);
    pushInst("R10", 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 1);
    for (int w = 0; w < 8; w++) begin
      logic [63:0] word;
      for (int b = 0; b < 8; b++) word[8*b +: 8] = stream[8*w + b];
      sendWord(32'h1000 + 32'(8*w), word);
    end
    repeat (12) @(negedge clk);
    check("queue drained", "R10", 64'(expQ.size()), 64'd0);

    // R11: stall with no word held
    doneMark = dones;
    check("needMore when empty", "R11", 64'(needMore), 64'd1);
    repeat (6) @(negedge clk);
    check("no completion while starved", "R11", 64'(dones), 64'(doneMark));

    // R2: start offset inside a word
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    startPc = 32'h2003;
    runPc = 32'h2003;
    pushInst("R2 R7", 0, 0, 0, 8'h6A, 0, 0, 0, 0, 0, 64'h7F, 2);
    pushInst("R2", 0, 0, 0, 8'hC3, 0, 0, 0, 0, 0, 0, 1);
    pushInst("R2", 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 1);
    pushInst("R2", 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 1);
    sendWord(32'h2000, 64'h9090_C37F_6AFF_FFFF);
    repeat (12) @(negedge clk);
    check("queue drained after offset start", "R2", 64'(expQ.size()), 64'd0);
    check("needMore after offset word", "R11", 64'(needMore), 64'd1);
    finishRun();
  end

endmodule